// File: doc/BRIEF.md
# FP32 to Unsigned Half-Precision Converter

This block turns one IEEE single-precision value per accepted transfer into a 16-bit unsigned half-precision code. The output code carries no sign: its upper 6 bits are a biased exponent (bias 31) and its lower 10 bits are the fraction. The all-ones exponent is kept for infinity and NaN, and results too small for a normal code are flushed to zero.

Each result also reports four exception flags: invalid, denormal-input, overflow and underflow. Negative inputs cannot be represented, so they behave like an operation without a defined result. Round-to-nearest-even or stochastic rounding is picked for each transfer. In stochastic mode the caller supplies fresh random bits with the data. The result is registered and appears with a one-cycle valid pulse on the cycle after acceptance.

Top module: `fp32_uhalf_conv`

## Requirements
- R1: While rstN is low, outValid, outCode and all four flags are 0 and inReady is 0. inReady becomes 1 on the first clock edge after reset is released.
- R2: A transfer is accepted on a rising edge where inValid and inReady are both 1. Its code and flags appear after that edge with outValid high for exactly one cycle. Without an accept, outValid is 0 and outCode and the flags keep their last values.
- R3: A positive normal input with FP32 exponent field E (97 to 158) whose low 13 fraction bits are zero gives outCode = {E-96 as 6 bits, top 10 fraction bits}, with no flag set. For example 1.0 gives 0x7C00.
- R4: With rndMode=0, the 13 dropped fraction bits round to nearest. An exact half (0x1000) rounds toward an even kept LSB.
- R5: With rndMode=1, rndBits (13 bits) is added to the 13 dropped fraction bits. A carry out of that sum adds one to the kept code, and there is no other rounding.
- R6: A positive finite input with E of 159 or more, or one whose rounding carries the exponent up to 63, gives infinity (0xFC00) with the overflow flag.
- R7: A positive normal input with E of 96 or less is flushed to 0x0000 with the underflow flag. The exponent test is made before rounding.
- R8: Any NaN input gives the canonical NaN code 0xFE00 (exponent 63, fraction 1000000000) with the invalid flag.
- R9: Positive infinity gives 0xFC00 with no flag. Negative infinity gives 0xFE00 with the invalid flag.
- R10: A negative nonzero normal input gives 0xFE00 with the invalid flag. Positive zero and negative zero give 0x0000 with no flag.
- R11: A denormal input (E=0, fraction nonzero) of either sign gives 0x0000 with only the denormal flag.
- R12: At most one flag is set in any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input data present |
| inReady | output | 1 | Block can take data |
| inData | input | 32 | FP32 operand |
| rndMode | input | 1 | 0 round to nearest even, 1 stochastic |
| rndBits | input | 13 | Random value for stochastic rounding |
| outValid | output | 1 | Result present (one cycle) |
| outCode | output | 16 | Unsigned half-precision result |
| flagInvalid | output | 1 | NaN or negative nonzero input |
| flagDenorm | output | 1 | Denormal input flushed |
| flagOverflow | output | 1 | Result saturated to infinity |
| flagUnderflow | output | 1 | Nonzero normal input flushed to zero |

## Verification
The bench builds the block with its default parameters: a 6-bit exponent and a 10-bit fraction. That makes the dropped field and the random input 13 bits wide and puts the flush and overflow boundaries at exponent fields 96/97 and 158/159. These widths allow each boundary to be hit with hand-computed codes: the largest finite code 0xFBFF, the rounding carry into infinity, and the minimum normal 0x0400. Ties to even on both LSB parities and stochastic carries at rndBits just below and at the carry point are exercised.

// File: rtl/uhc_pkg.sv
package uhc_pkg;
  localparam int F32_EXP_W = 8;
  localparam int F32_MAN_W = 23;
  localparam int F32_BIAS  = 127;

  typedef struct packed {
    logic load;
  } uhc_ctl_t;
endpackage

// File: rtl/uhc_ctrl.sv
module uhc_ctrl
  import uhc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output logic     inReady,
  output logic     outValid,
  output uhc_ctl_t ctl
);
  logic readyQ;
  logic validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      validQ <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      validQ <= inValid & readyQ;
    end
  end

  always_comb begin
    ctl.load = inValid & readyQ;
  end

  assign inReady  = readyQ;
  assign outValid = validQ;

  // R2: a result is only presented after a cycle in which the block was ready
  p_valid_needs_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inReady));
endmodule

// File: rtl/uhc_datapath.sv
module uhc_datapath
  import uhc_pkg::*;
#(
  parameter int EXP_W = 6,
  parameter int MAN_W = 10,
  localparam int OUT_W  = EXP_W + MAN_W,
  localparam int DROP_W = F32_MAN_W - MAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  uhc_ctl_t          ctl,
  input  logic [31:0]       inData,
  input  logic              rndMode,
  input  logic [DROP_W-1:0] rndBits,
  output logic [OUT_W-1:0]  outCode,
  output logic              flagInvalid,
  output logic              flagDenorm,
  output logic              flagOverflow,
  output logic              flagUnderflow
);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int SHIFT   = F32_BIAS - BIAS;
  localparam int EXP_TOP = (1 << EXP_W) - 1;
  localparam logic [OUT_W-1:0] CODE_INF = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [OUT_W-1:0] CODE_NAN = {{EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [DROP_W-1:0] HALF    = {1'b1, {(DROP_W-1){1'b0}}};

  logic                 sgn;
  logic [F32_EXP_W-1:0] expF;
  logic [F32_MAN_W-1:0] manF;
  logic [MAN_W-1:0]     keep;
  logic [DROP_W-1:0]    lost;
  logic [DROP_W:0]      stochSum;
  logic                 rndUp;
  int                   tgtExp;
  logic [OUT_W:0]       rounded;

  logic [OUT_W-1:0] codeD;
  logic             invD, denD, ovfD, unfD;

  assign sgn  = inData[31];
  assign expF = inData[30:F32_MAN_W];
  assign manF = inData[F32_MAN_W-1:0];
  assign keep = manF[F32_MAN_W-1 -: MAN_W];
  assign lost = manF[DROP_W-1:0];

  always_comb begin
    stochSum = {1'b0, lost} + {1'b0, rndBits};
    if (rndMode)
      rndUp = stochSum[DROP_W];
    else
      rndUp = (lost > HALF) || ((lost == HALF) && keep[0]);
    tgtExp  = int'(expF) - SHIFT;
    rounded = {1'b0, tgtExp[EXP_W-1:0], keep} + {{OUT_W{1'b0}}, rndUp};
  end

  always_comb begin
    codeD = '0;
    invD  = 1'b0;
    denD  = 1'b0;
    ovfD  = 1'b0;
    unfD  = 1'b0;
    if (expF == '1) begin
      if (manF != '0 || sgn) begin
        codeD = CODE_NAN;
        invD  = 1'b1;
      end else begin
        codeD = CODE_INF;
      end
    end else if (expF == '0) begin
      denD = (manF != '0);
    end else if (sgn) begin
      codeD = CODE_NAN;
      invD  = 1'b1;
    end else if (tgtExp <= 0) begin
      unfD = 1'b1;
    end else if (tgtExp >= EXP_TOP || rounded[OUT_W-1 -: EXP_W] == EXP_W'(EXP_TOP)) begin
      codeD = CODE_INF;
      ovfD  = 1'b1;
    end else begin
      codeD = rounded[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCode       <= '0;
      flagInvalid   <= 1'b0;
      flagDenorm    <= 1'b0;
      flagOverflow  <= 1'b0;
      flagUnderflow <= 1'b0;
    end else if (ctl.load) begin
      outCode       <= codeD;
      flagInvalid   <= invD;
      flagDenorm    <= denD;
      flagOverflow  <= ovfD;
      flagUnderflow <= unfD;
    end
  end

  p_nan_canonical_r8: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalid |-> outCode == CODE_NAN);
  p_ovf_is_inf_r6: assert property (@(posedge clk) disable iff (!rstN)
    flagOverflow |-> outCode == CODE_INF);
  p_unf_is_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    flagUnderflow |-> outCode == '0);
  p_den_is_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    flagDenorm |-> outCode == '0);
  p_one_flag_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flagInvalid, flagDenorm, flagOverflow, flagUnderflow}));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(outCode));
endmodule

// File: rtl/fp32_uhalf_conv.sv
module fp32_uhalf_conv
  import uhc_pkg::*;
#(
  parameter int EXP_W = 6,
  parameter int MAN_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [31:0]              inData,
  input  logic                     rndMode,
  input  logic [22-MAN_W:0]        rndBits,
  output logic                     outValid,
  output logic [EXP_W+MAN_W-1:0]   outCode,
  output logic                     flagInvalid,
  output logic                     flagDenorm,
  output logic                     flagOverflow,
  output logic                     flagUnderflow
);
  uhc_ctl_t ctl;

  uhc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  uhc_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .inData        (inData),
    .rndMode       (rndMode),
    .rndBits       (rndBits),
    .outCode       (outCode),
    .flagInvalid   (flagInvalid),
    .flagDenorm    (flagDenorm),
    .flagOverflow  (flagOverflow),
    .flagUnderflow (flagUnderflow)
  );
endmodule

// File: tb/sim_fp32_uhalf_conv.sv
`timescale 1ns/1ps
module sim_fp32_uhalf_conv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic        rndMode = 1'b0;
  logic [12:0] rndBits = '0;
  logic        outValid;
  logic [15:0] outCode;
  logic        flagInvalid, flagDenorm, flagOverflow, flagUnderflow;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fp32_uhalf_conv u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .rndMode(rndMode), .rndBits(rndBits),
    .outValid(outValid), .outCode(outCode), .flagInvalid(flagInvalid),
    .flagDenorm(flagDenorm), .flagOverflow(flagOverflow),
    .flagUnderflow(flagUnderflow)
  );

  function automatic logic [3:0] flags();
    return {flagInvalid, flagDenorm, flagOverflow, flagUnderflow};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flags order {invalid, denorm, overflow, underflow}
  task automatic conv(input string req, input logic [31:0] x, input logic mode,
                      input logic [12:0] r, input logic [15:0] expCode,
                      input logic [3:0] expFlags);
    @(negedge clk);
    inData = x; rndMode = mode; rndBits = r; inValid = 1'b1;
    @(posedge clk); #1;
    check(req, {11'd0, outValid, flags(), outCode}, {11'd0, 1'b1, expFlags, expCode});
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    #12;
    check("R1 reset", {11'd0, inReady, outValid, flags(), outCode}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 ready", {31'd0, inReady}, 32'd1);
  endtask

  task automatic testHandshake();
    conv("R2 accept", 32'h3FC00000, 1'b0, '0, 16'h7E00, 4'b0000);
    @(posedge clk); #1;
    check("R2 one-cycle", {31'd0, outValid}, 32'd0);
    @(negedge clk); inData = 32'h40000000;
    repeat (2) @(posedge clk); #1;
    check("R2 hold", {11'd0, outValid, flags(), outCode}, {11'd0, 1'b0, 4'b0000, 16'h7E00});
  endtask

  task automatic testNormal();
    conv("R3 one", 32'h3F800000, 1'b0, '0, 16'h7C00, 4'b0000);
    conv("R3 two", 32'h40000000, 1'b0, '0, 16'h8000, 4'b0000);
    conv("R3 minnorm", 32'h30800000, 1'b0, '0, 16'h0400, 4'b0000);
    conv("R3 maxfinite", 32'h4F7FE000, 1'b0, '0, 16'hFBFF, 4'b0000);
  endtask

  task automatic testNearest();
    conv("R4 tie even down", 32'h3F801000, 1'b0, '0, 16'h7C00, 4'b0000);
    conv("R4 tie odd up", 32'h3F803000, 1'b0, '0, 16'h7C02, 4'b0000);
    conv("R4 above half", 32'h3F801001, 1'b0, '0, 16'h7C01, 4'b0000);
    conv("R4 below half", 32'h3F800FFF, 1'b0, '0, 16'h7C00, 4'b0000);
  endtask

  task automatic testStochastic();
    conv("R5 carry", 32'h3F800001, 1'b1, 13'h1FFF, 16'h7C01, 4'b0000);
    conv("R5 no carry", 32'h3F800001, 1'b1, 13'h1FFE, 16'h7C00, 4'b0000);
    conv("R5 half no rand", 32'h3F803000, 1'b1, 13'h0000, 16'h7C01, 4'b0000);
  endtask

  task automatic testOverflow();
    conv("R6 big exp", 32'h4F800000, 1'b0, '0, 16'hFC00, 4'b0010);
    conv("R6 round carry", 32'h4F7FF000, 1'b0, '0, 16'hFC00, 4'b0010);
    conv("R6 huge", 32'h7F7FFFFF, 1'b0, '0, 16'hFC00, 4'b0010);
  endtask

  task automatic testUnderflow();
    conv("R7 tiny", 32'h30000000, 1'b0, '0, 16'h0000, 4'b0001);
    conv("R7 tiny round", 32'h307FFFFF, 1'b0, '0, 16'h0000, 4'b0001);
  endtask

  task automatic testSpecials();
    conv("R8 qnan", 32'h7FC00000, 1'b0, '0, 16'hFE00, 4'b1000);
    conv("R8 snan", 32'h7F800001, 1'b0, '0, 16'hFE00, 4'b1000);
    conv("R9 +inf", 32'h7F800000, 1'b0, '0, 16'hFC00, 4'b0000);
    conv("R9 -inf", 32'hFF800000, 1'b0, '0, 16'hFE00, 4'b1000);
    conv("R10 neg one", 32'hBF800000, 1'b0, '0, 16'hFE00, 4'b1000);
    conv("R10 +zero", 32'h00000000, 1'b0, '0, 16'h0000, 4'b0000);
    conv("R10 -zero", 32'h80000000, 1'b0, '0, 16'h0000, 4'b0000);
    conv("R11 +denorm", 32'h00000001, 1'b0, '0, 16'h0000, 4'b0100);
    conv("R11 -denorm", 32'h807FFFFF, 1'b0, '0, 16'h0000, 4'b0100);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    testReset();
    testHandshake();
    testNormal();
    testNearest();
    testStochastic();
    testOverflow();
    testUnderflow();
    testSpecials(); // R12: every expected flag vector above has at most one bit set
    finished = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
    end
  end
endmodule